// File: doc/BRIEF.md
# Paired-Single Byte-Align Execution Unit

This unit decodes and executes a single floating-point coprocessor instruction. The instruction takes two 64-bit floating-point register values, each holding a pair of single-precision numbers. It joins them and funnel-shifts the joined value by a byte offset. The offset comes from a general-purpose register value. Software uses the result to realign a paired-single vector that was loaded from, or is about to be stored to, an address that sits on a 4-byte boundary rather than an 8-byte one.

The surrounding pipeline supplies the following on a valid strobe:

- the instruction word;
- the two source register values;
- the offset register value;
- the current byte order;
- the register-mode state of the floating-point unit;
- whether the coprocessor is enabled.

One cycle later the unit returns the aligned result, the destination register index and a write enable. It also returns an indication that the result is unpredictable, and two exception flags: one for an unusable coprocessor and one for a reserved instruction.

The move is purely a data move. The unit has no arithmetic and no path that could raise or record a floating-point exception.

Top module: `psalign_unit`

## Requirements
- R1: One cycle after a strobe on `in_valid`, `out_valid` is high for exactly one cycle. `dest_idx` carries instruction bits 10:6. A cycle without a strobe leaves `out_valid`, `wr_en`, `unpredictable`, `exc_cop_unusable` and `exc_reserved` low.
- R2: With offset bits 2:0 equal to 0, the result equals the `fs_val` input unchanged. Offset bits above bit 2 have no effect on the result.
- R3: With offset bits 2:0 equal to 4 and `big_endian` high, the result is `fs_val[31:0]` in bits 63:32 and `ft_val[63:32]` in bits 31:0.
- R4: With offset bits 2:0 equal to 4 and `big_endian` low, the result is `ft_val[31:0]` in bits 63:32 and `fs_val[63:32]` in bits 31:0.
- R5: A nonzero value in offset bits 1:0 raises `unpredictable` and keeps `wr_en` low.
- R6: With `fr64` low (32-bit register mode), the unit raises `unpredictable` and keeps `wr_en` low, whatever the offset.
- R7: When instruction bits 31:26 equal 010011 and `cop_en` is low, the unit raises `exc_cop_unusable` and keeps `wr_en` low.
- R8: The unit raises `exc_reserved` and keeps `wr_en` low in either of two cases: instruction bits 31:26 differ from 010011, or `cop_en` is high and bits 5:0 differ from 011110.
- R9: At most one exception flag is high at a time. While an exception flag is high, `unpredictable` stays low.
- R10: Whenever `wr_en` is low, `result` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: inputs hold an instruction to execute |
| instr | input | 32 | Instruction word |
| fs_val | input | 64 | First source paired-single value |
| ft_val | input | 64 | Second source paired-single value |
| off_val | input | 64 | General-purpose register value giving the byte offset |
| big_endian | input | 1 | 1 = big-endian byte order |
| fr64 | input | 1 | 1 = 64-bit register mode |
| cop_en | input | 1 | 1 = floating-point coprocessor enabled |
| out_valid | output | 1 | Result cycle marker |
| result | output | 64 | Aligned value, zero when not written |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Destination register write enable |
| unpredictable | output | 1 | Offset or register mode makes the result undefined |
| exc_cop_unusable | output | 1 | Coprocessor unusable exception |
| exc_reserved | output | 1 | Reserved instruction exception |

## Verification
The hardest cases to reach are those where two fault conditions meet and priority decides the outcome. One is a disabled coprocessor combined with a bad function field. Another is an exception together with a misaligned offset in 32-bit mode. In both, only one flag may survive, and `unpredictable` must yield to the exception. The bench builds instruction words field by field, so it can set the major opcode, the function field, `cop_en`, `fr64` and the offset into each of these clashing combinations in one strobe. It also pads the offset with nonzero upper bits, to show that only the low three bits steer the shift.

// File: rtl/psalign_unit.sv
module psalign_unit #(
  parameter int REG_W = 64,
  parameter int IW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IW-1:0]    instr,
  input  logic [REG_W-1:0] fs_val,
  input  logic [REG_W-1:0] ft_val,
  input  logic [REG_W-1:0] off_val,
  input  logic             big_endian,
  input  logic             fr64,
  input  logic             cop_en,
  output logic             out_valid,
  output logic [REG_W-1:0] result,
  output logic [IDX_W-1:0] dest_idx,
  output logic             wr_en,
  output logic             unpredictable,
  output logic             exc_cop_unusable,
  output logic             exc_reserved
);
  localparam int HALF = REG_W / 2;
  localparam logic [5:0] MAJOR = 6'b010011;
  localparam logic [5:0] FUNC  = 6'b011110;

  logic maj_ok, fn_ok, cpu_c, rsv_c, unp_c, ok_c;
  logic [REG_W-1:0] swapped, aligned;

  assign maj_ok = (instr[IW-1 -: 6] == MAJOR);
  assign fn_ok  = (instr[5:0] == FUNC);
  assign cpu_c  = maj_ok & ~cop_en;
  assign rsv_c  = ~maj_ok | (cop_en & ~fn_ok);
  assign unp_c  = ~(cpu_c | rsv_c) & (~fr64 | (|off_val[1:0]));
  assign ok_c   = ~(cpu_c | rsv_c | unp_c);

  assign swapped = big_endian ? {fs_val[HALF-1:0], ft_val[REG_W-1:HALF]}
                              : {ft_val[HALF-1:0], fs_val[REG_W-1:HALF]};
  assign aligned = off_val[2] ? swapped : fs_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid        <= 1'b0;
      result           <= '0;
      dest_idx         <= '0;
      wr_en            <= 1'b0;
      unpredictable    <= 1'b0;
      exc_cop_unusable <= 1'b0;
      exc_reserved     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dest_idx         <= instr[10:6];
        wr_en            <= ok_c;
        result           <= ok_c ? aligned : '0;
        unpredictable    <= unp_c;
        exc_cop_unusable <= cpu_c;
        exc_reserved     <= rsv_c;
      end else begin
        wr_en            <= 1'b0;
        result           <= '0;
        unpredictable    <= 1'b0;
        exc_cop_unusable <= 1'b0;
        exc_reserved     <= 1'b0;
      end
    end
  end

  p_strobe_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_en && !exc_reserved && !exc_cop_unusable);
  p_zero_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 (wr_en && $past(off_val[2:0]) == 3'd0) |-> result == $past(fs_val));
  p_bad_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && maj_ok && fn_ok && cop_en && (|off_val[1:0]) |=> unpredictable && !wr_en);
  p_single_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_cop_unusable, exc_reserved}) && !((exc_cop_unusable || exc_reserved) && unpredictable));
  p_write_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid && !unpredictable && !exc_cop_unusable && !exc_reserved);
  p_quiet_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> result == '0);
endmodule

// File: tb/psalign_unit_bench.sv
module psalign_unit_bench;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] instr = '0;
  logic [63:0] fs_val = '0, ft_val = '0, off_val = '0;
  logic big_endian = 0, fr64 = 1, cop_en = 1;
  logic out_valid, wr_en, unpredictable, exc_cop_unusable, exc_reserved;
  logic [63:0] result;
  logic [4:0] dest_idx;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psalign_unit u_psalign_unit (.*);

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] rs,
      input logic [4:0] ft, input logic [4:0] fs, input logic [4:0] fd, input logic [5:0] fn);
    return {maj, rs, ft, fs, fd, fn};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] t,
      input logic [63:0] o, input logic be, input logic fr, input logic ce);
    instr = ins; fs_val = s; ft_val = t; off_val = o;
    big_endian = be; fr64 = fr; cop_en = ce; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic expect_out(input string req, input logic [63:0] res, input logic we,
      input logic unp, input logic cpu, input logic rsv);
    chk(req, "out_valid", {63'd0, out_valid}, 64'd1);
    chk(req, "result", result, res);
    chk(req, "wr_en", {63'd0, wr_en}, {63'd0, we});
    chk(req, "unpredictable", {63'd0, unpredictable}, {63'd0, unp});
    chk(req, "cop_unusable", {63'd0, exc_cop_unusable}, {63'd0, cpu});
    chk(req, "reserved", {63'd0, exc_reserved}, {63'd0, rsv});
  endtask

  localparam logic [63:0] A = 64'h1111_2222_3333_4444;
  localparam logic [63:0] B = 64'hAAAA_BBBB_CCCC_DDDD;

  task automatic t_reset();
    chk("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R10", "reset result", result, 64'd0);
    chk("R1", "reset wr_en", {63'd0, wr_en}, 64'd0);
  endtask

  task automatic t_offset0();
    fire(mk(6'b010011, 5'd3, 5'd2, 5'd1, 5'd17, 6'b011110), A, B, 64'h0, 1, 1, 1);
    expect_out("R2", A, 1, 0, 0, 0);
    chk("R1", "dest_idx", {59'd0, dest_idx}, 64'd17);
    fire(mk(6'b010011, 5'd3, 5'd2, 5'd1, 5'd9, 6'b011110), B, A, 64'hFFFF_FFFF_FFFF_FFF8, 0, 1, 1);
    expect_out("R2", B, 1, 0, 0, 0);
    chk("R1", "dest_idx", {59'd0, dest_idx}, 64'd9);
  endtask

  task automatic t_offset4();
    fire(mk(6'b010011, 5'd4, 5'd5, 5'd6, 5'd31, 6'b011110), A, B, 64'h4, 1, 1, 1);
    expect_out("R3", {A[31:0], B[63:32]}, 1, 0, 0, 0);
    chk("R1", "dest_idx", {59'd0, dest_idx}, 64'd31);
    fire(mk(6'b010011, 5'd4, 5'd5, 5'd6, 5'd0, 6'b011110), A, B, 64'h4, 0, 1, 1);
    expect_out("R4", {B[31:0], A[63:32]}, 1, 0, 0, 0);
    fire(mk(6'b010011, 5'd4, 5'd5, 5'd6, 5'd2, 6'b011110), B, A, 64'hF0C, 0, 1, 1);
    expect_out("R4", {A[31:0], B[63:32]}, 1, 0, 0, 0);
  endtask

  task automatic t_bad_offset();
    for (int k = 1; k < 8; k++) begin
      if (k == 4) continue;
      fire(mk(6'b010011, 5'd1, 5'd2, 5'd3, 5'd4, 6'b011110), A, B, 64'(k), k[0], 1, 1);
      expect_out("R5", 64'd0, 0, 1, 0, 0);
    end
  endtask

  task automatic t_fr0();
    fire(mk(6'b010011, 5'd1, 5'd2, 5'd3, 5'd4, 6'b011110), A, B, 64'h0, 1, 0, 1);
    expect_out("R6", 64'd0, 0, 1, 0, 0);
    fire(mk(6'b010011, 5'd1, 5'd2, 5'd3, 5'd4, 6'b011110), A, B, 64'h4, 0, 0, 1);
    expect_out("R6", 64'd0, 0, 1, 0, 0);
  endtask

  task automatic t_cop_off();
    fire(mk(6'b010011, 5'd1, 5'd2, 5'd3, 5'd4, 6'b011110), A, B, 64'h0, 1, 1, 0);
    expect_out("R7", 64'd0, 0, 0, 1, 0);
    fire(mk(6'b010011, 5'd1, 5'd2, 5'd3, 5'd4, 6'b000001), A, B, 64'h3, 1, 0, 0);
    expect_out("R9", 64'd0, 0, 0, 1, 0);
  endtask

  task automatic t_reserved();
    fire(mk(6'b010001, 5'd1, 5'd2, 5'd3, 5'd4, 6'b011110), A, B, 64'h0, 1, 1, 1);
    expect_out("R8", 64'd0, 0, 0, 0, 1);
    fire(mk(6'b010011, 5'd1, 5'd2, 5'd3, 5'd4, 6'b011111), A, B, 64'h0, 1, 1, 1);
    expect_out("R8", 64'd0, 0, 0, 0, 1);
    fire(mk(6'b000000, 5'd1, 5'd2, 5'd3, 5'd4, 6'b011110), A, B, 64'h0, 1, 1, 0);
    expect_out("R8", 64'd0, 0, 0, 0, 1);
    fire(mk(6'b010011, 5'd1, 5'd2, 5'd3, 5'd4, 6'b111110), A, B, 64'h2, 0, 0, 1);
    expect_out("R9", 64'd0, 0, 0, 0, 1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R1", "idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R10", "idle result", result, 64'd0);
    chk("R1", "idle wr_en", {63'd0, wr_en}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_offset0();
    t_offset4();
    t_idle();
    t_bad_offset();
    t_fr0();
    t_cop_off();
    t_reserved();
    t_idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule